// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block gathers a parameterized set of interrupt request lines (eight by default), keeps a pending bit per line, and filters the pending set through a mask. Among unmasked pending lines that are not held off by a line already in service, it picks the one with the lowest index and drives a single interrupt output. When the processor strobes acknowledge, the controller marks the winner as in service and, one cycle later, presents an 8-bit vector made of a programmable 5-bit base followed by the 3-bit line number. A non-specific end-of-interrupt strobe retires the highest-priority line in service.

Each line can be edge or level sensitive. The two modes differ only at the leading edge. Edge mode needs a low-to-high transition to set the pending bit. In both modes a pending bit is dropped again as soon as its input goes low before it is acknowledged. If nothing eligible is left when acknowledge arrives, the controller answers with the spurious vector for line 7 by itself.

For cascading, a second instance can act as a subordinate. Its `cascade_out` is a continuous level, high while it holds any unmasked pending request. That level feeds one input of the main instance, and that input is designated as the cascade line. The main instance pulses `casc_sel` instead of producing a vector only when the cascade line still wins at acknowledge time. A vanished subordinate request therefore yields the main instance's own line-7 spurious vector, and never a subordinate one.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A line in edge mode (trigger bit 0) becomes pending only when its input is high in a cycle after it was sampled low. An input held high after service raises no new request until it falls and rises again.
- R2: A line in level mode (trigger bit 1) is pending whenever its input is high. After acknowledge and end-of-interrupt it requests again while the input stays high.
- R3: In either mode, a pending request whose input goes low before acknowledge is cleared, and `int_out` falls.
- R4: A line whose mask bit is 1 is never granted, even if its request was latched before the mask was written.
- R5: Among eligible lines, the lowest index wins.
- R6: While a line is in service, lines of equal or lower priority (equal or higher index) do not raise `int_out`. A line of higher priority still does.
- R7: An end-of-interrupt strobe clears only the in-service bit of the highest-priority (lowest index) line in service.
- R8: The cycle after acknowledge, `vec_valid` is high for one cycle and `vec_out` = {base[4:0], line[2:0]}, with the line number in bits 2:0.
- R9: If no line is eligible at acknowledge, `vec_out` = {base, 3'b111}, `vec_valid` is high and no in-service bit is set.
- R10: `cascade_out` is high exactly while some unmasked request is pending, regardless of what is in service.
- R11: When cascading is enabled (config select 3, bit 3 = enable, bits 2:0 = line), the cascade line is always level sensitive. If that line wins at acknowledge, `casc_sel` pulses for one cycle, `vec_valid` stays low and the line goes into service.
- R12: Reset leaves all lines masked, nothing pending or in service, and `int_out`, `cascade_out`, `vec_valid` and `casc_sel` all low. Config selects: 0 = mask (1 masks a line), 1 = trigger mode, 2 = vector base in bits 4:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_LINES | Request inputs |
| cfg_we | input | 1 | Config write strobe |
| cfg_sel | input | 2 | Config register select |
| cfg_wdata | input | NUM_LINES | Config write data |
| ack | input | 1 | Interrupt acknowledge strobe |
| eoi | input | 1 | Non-specific end-of-interrupt strobe |
| int_out | output | 1 | Interrupt request to the processor |
| cascade_out | output | 1 | Unmasked-pending level for a cascading parent |
| vec_valid | output | 1 | Vector valid, one cycle after acknowledge |
| vec_out | output | VEC_W | Base concatenated with line number |
| casc_sel | output | 1 | Subordinate must supply the vector |

## Verification
The bench targets requests that vanish before acknowledge: an edge line that falls early, a line masked after it latched, and a cascade input that drops. A design that kept such a request latched would return a real vector or pulse `casc_sel` where the line-7 spurious vector belongs. It holds an edge input high through service to catch a design that re-requests on level. It also checks that a level line does re-request after end-of-interrupt. It nests a higher-priority service inside a lower one and follows with an end-of-interrupt. A design that retired the wrong in-service bit would then block a line of middle priority that should reach `int_out`.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
   typedef enum logic [1:0] {
      CFG_MASK = 2'd0,
      CFG_TRIG = 2'd1,
      CFG_BASE = 2'd2,
      CFG_CASC = 2'd3
   } cfg_sel_e;
endpackage

// File: rtl/irq_line_latch.sv
module irq_line_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   input  logic level_mode,
   input  logic take,
   output logic req
);
   logic prev_q;
   logic req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         req_q  <= 1'b0;
      end else begin
         prev_q <= line_in;
         if (!line_in || take)
            req_q <= 1'b0;
         else if (level_mode || !prev_q)
            req_q <= 1'b1;
      end
   end

   assign req = req_q;

   // R1: in edge mode a line already seen high cannot become pending
   a_r1_edge_needs_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (!level_mode && !req_q && prev_q) |=> !req_q);

   // R3: a low input always drops the pending bit
   a_r3_drop_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !line_in |=> !req_q);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int NUM_LINES = 8,
   localparam int LW = $clog2(NUM_LINES)
) (
   input  logic [NUM_LINES-1:0] pend,
   input  logic [NUM_LINES-1:0] isr,
   output logic                 win_valid,
   output logic [LW-1:0]        win_idx
);
   logic blocked;

   always_comb begin
      blocked   = 1'b0;
      win_valid = 1'b0;
      win_idx   = '0;
      for (int i = 0; i < NUM_LINES; i++) begin
         if (!blocked && !win_valid) begin
            if (isr[i])
               blocked = 1'b1;
            else if (pend[i]) begin
               win_valid = 1'b1;
               win_idx   = LW'(i);
            end
         end
      end
   end

   // R5/R6: a winner is pending and nothing at or above it is in service
   always_comb begin
      if (win_valid) begin
         a_r5_winner_pending: assert (pend[win_idx]);
         a_r6_no_isr_above: assert ((isr & ((NUM_LINES'(1) << win_idx) << 1) - NUM_LINES'(1)) == '0);
      end
   end
endmodule

// File: rtl/irq_service.sv
module irq_service #(
   parameter int NUM_LINES = 8,
   localparam int LW = $clog2(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 grant,
   input  logic [LW-1:0]        grant_idx,
   input  logic                 eoi,
   output logic [NUM_LINES-1:0] isr
);
   logic [NUM_LINES-1:0] isr_q;
   logic [NUM_LINES-1:0] retire;
   logic [NUM_LINES-1:0] enter;

   assign retire = eoi   ? (isr_q & (~isr_q + NUM_LINES'(1))) : '0;
   assign enter  = grant ? (NUM_LINES'(1) << grant_idx)       : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         isr_q <= '0;
      else
         isr_q <= (isr_q & ~retire) | enter;
   end

   assign isr = isr_q;

   // R7: one end-of-interrupt retires exactly one bit
   a_r7_eoi_retires_one: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && !grant && (isr_q != '0)) |=> ($countones(isr_q) + 1 == $past($countones(isr_q))));

   // R8: a grant places its line in service
   a_r8_grant_enters: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && !eoi) |=> isr_q[$past(grant_idx)]);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
   parameter int NUM_LINES       = 8,
   parameter int VEC_W           = 8,
   parameter bit CASCADE_CAPABLE = 1'b1,
   localparam int LW     = $clog2(NUM_LINES),
   localparam int BASE_W = VEC_W - LW
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_in,
   input  logic                 cfg_we,
   input  logic [1:0]           cfg_sel,
   input  logic [NUM_LINES-1:0] cfg_wdata,
   input  logic                 ack,
   input  logic                 eoi,
   output logic                 int_out,
   output logic                 cascade_out,
   output logic                 vec_valid,
   output logic [VEC_W-1:0]     vec_out,
   output logic                 casc_sel
);
   import irq_ctrl_pkg::*;

   if (NUM_LINES < 2 || (NUM_LINES & (NUM_LINES - 1)) != 0) begin : g_bad_lines
      $error("NUM_LINES must be a power of two of at least 2");
   end
   if (BASE_W < 1 || BASE_W > NUM_LINES) begin : g_bad_vec
      $error("VEC_W must leave a base field that fits the write data");
   end
   if (LW + 1 > NUM_LINES) begin : g_bad_casc
      $error("cascade config field does not fit the write data");
   end

   logic [NUM_LINES-1:0] imr_q;
   logic [NUM_LINES-1:0] lvl_q;
   logic [BASE_W-1:0]    base_q;
   logic                 casc_en;
   logic [LW-1:0]        casc_line;

   logic [NUM_LINES-1:0] req;
   logic [NUM_LINES-1:0] pend;
   logic [NUM_LINES-1:0] isr;
   logic [NUM_LINES-1:0] take;
   logic [NUM_LINES-1:0] line_lvl;
   logic                 win_valid;
   logic [LW-1:0]        win_idx;
   logic                 grant;
   logic                 to_casc;

   logic                 vec_valid_q;
   logic [VEC_W-1:0]     vec_q;
   logic                 casc_sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         imr_q  <= '1;
         lvl_q  <= '0;
         base_q <= '0;
      end else if (cfg_we) begin
         case (cfg_sel_e'(cfg_sel))
            CFG_MASK: imr_q  <= cfg_wdata;
            CFG_TRIG: lvl_q  <= cfg_wdata;
            CFG_BASE: base_q <= cfg_wdata[BASE_W-1:0];
            default:  ;
         endcase
      end
   end

   if (CASCADE_CAPABLE) begin : g_casc
      logic          en_q;
      logic [LW-1:0] line_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_q   <= 1'b0;
            line_q <= '0;
         end else if (cfg_we && cfg_sel_e'(cfg_sel) == CFG_CASC) begin
            en_q   <= cfg_wdata[LW];
            line_q <= cfg_wdata[LW-1:0];
         end
      end
      assign casc_en   = en_q;
      assign casc_line = line_q;
   end else begin : g_no_casc
      assign casc_en   = 1'b0;
      assign casc_line = '0;
   end

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      assign line_lvl[i] = lvl_q[i] | (casc_en && casc_line == LW'(i));
      assign take[i]     = grant && win_idx == LW'(i);
      irq_line_latch u_latch (
         .clk        (clk),
         .rst_n      (rst_n),
         .line_in    (irq_in[i]),
         .level_mode (line_lvl[i]),
         .take       (take[i]),
         .req        (req[i])
      );
   end

   assign pend = req & ~imr_q;

   irq_prio_pick #(.NUM_LINES(NUM_LINES)) u_pick (
      .pend      (pend),
      .isr       (isr),
      .win_valid (win_valid),
      .win_idx   (win_idx)
   );

   assign grant   = ack && win_valid;
   assign to_casc = casc_en && win_idx == casc_line;

   irq_service #(.NUM_LINES(NUM_LINES)) u_svc (
      .clk       (clk),
      .rst_n     (rst_n),
      .grant     (grant),
      .grant_idx (win_idx),
      .eoi       (eoi),
      .isr       (isr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_valid_q <= 1'b0;
         vec_q       <= '0;
         casc_sel_q  <= 1'b0;
      end else begin
         vec_valid_q <= 1'b0;
         casc_sel_q  <= 1'b0;
         if (ack) begin
            if (win_valid && to_casc)
               casc_sel_q <= 1'b1;
            else begin
               vec_valid_q <= 1'b1;
               vec_q       <= {base_q, (win_valid ? win_idx : {LW{1'b1}})};
            end
         end
      end
   end

   assign int_out     = win_valid;
   assign cascade_out = |pend;
   assign vec_valid   = vec_valid_q;
   assign vec_out     = vec_q;
   assign casc_sel    = casc_sel_q;

   // R4: a masked line is never granted
   a_r4_mask_blocks_grant: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> !imr_q[win_idx]);

   // R9: nothing eligible at acknowledge gives the line-7 vector
   a_r9_spurious_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !int_out) |=> (vec_valid && vec_out[LW-1:0] == {LW{1'b1}} && !casc_sel));

   // R11: cascade select only while the cascade line is still pending
   a_r11_casc_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !(casc_en && pend[casc_line])) |=> !casc_sel);

   // R8: vector and cascade select never coincide
   a_r8_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
      !(vec_valid && casc_sel));
endmodule

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
   import irq_ctrl_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq = '0;
   logic       cfg_we = 1'b0;
   logic [1:0] cfg_sel = '0;
   logic [7:0] cfg_wdata = '0;
   logic       ack = 1'b0;
   logic       eoi = 1'b0;
   logic       int_out, cascade_out, vec_valid, casc_sel;
   logic [7:0] vec_out;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  run_cmp = 1'b0;
   bit  done = 1'b0;

   always #4 clk = ~clk;

   irq_prio_ctrl dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .ack(ack), .eoi(eoi), .int_out(int_out),
      .cascade_out(cascade_out), .vec_valid(vec_valid), .vec_out(vec_out),
      .casc_sel(casc_sel)
   );

   // reference model state
   logic [7:0] m_irr, m_isr, m_prev, m_imr, m_trig;
   logic [4:0] m_base;
   logic       m_cen, m_vv, m_cs;
   logic [2:0] m_cline;
   logic [7:0] m_vec;

   function automatic int m_win();
      int h = 8;
      int w = -1;
      for (int i = 7; i >= 0; i--) if (m_isr[i]) h = i;
      for (int i = h - 1; i >= 0; i--) if (m_irr[i] && !m_imr[i]) w = i;
      return w;
   endfunction

   always @(posedge clk) begin : model
      int w, h;
      logic [7:0] nirr, nisr;
      bit lvl;
      if (!rst_n) begin
         m_irr = '0; m_isr = '0; m_prev = '0; m_imr = '1; m_trig = '0;
         m_base = '0; m_cen = 1'b0; m_cline = '0; m_vv = 1'b0; m_cs = 1'b0; m_vec = '0;
      end else begin
         w = m_win();
         h = 8;
         for (int i = 7; i >= 0; i--) if (m_isr[i]) h = i;
         nisr = m_isr;
         if (eoi && h < 8) nisr[h] = 1'b0;
         if (ack && w >= 0) nisr[w] = 1'b1;
         m_vv = 1'b0; m_cs = 1'b0;
         if (ack) begin
            if (w >= 0 && m_cen && w == int'(m_cline)) m_cs = 1'b1;
            else begin
               m_vv = 1'b1;
               m_vec = {m_base, (w >= 0) ? 3'(w) : 3'd7};
            end
         end
         for (int i = 0; i < 8; i++) begin
            lvl = m_trig[i] || (m_cen && int'(m_cline) == i);
            if (!irq[i] || (ack && w == i)) nirr[i] = 1'b0;
            else if (lvl || !m_prev[i]) nirr[i] = 1'b1;
            else nirr[i] = m_irr[i];
         end
         m_prev = irq; m_irr = nirr; m_isr = nisr;
         if (cfg_we) begin
            case (cfg_sel)
               2'd0: m_imr = cfg_wdata;
               2'd1: m_trig = cfg_wdata;
               2'd2: m_base = cfg_wdata[4:0];
               default: begin m_cen = cfg_wdata[3]; m_cline = cfg_wdata[2:0]; end
            endcase
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (run_cmp && rst_n) begin
         chk("R5 int_out vs model", 32'(int_out), 32'(m_win() >= 0));
         chk("R10 cascade_out vs model", 32'(cascade_out), 32'(|(m_irr & ~m_imr)));
         chk("R8 vec_valid vs model", 32'(vec_valid), 32'(m_vv));
         chk("R11 casc_sel vs model", 32'(casc_sel), 32'(m_cs));
         if (m_vv) chk("R8 vec_out vs model", 32'(vec_out), 32'(m_vec));
      end
   end

   task automatic cyc(input int n = 1);
      repeat (n) begin @(posedge clk); #2; end
   endtask

   task automatic wr(input cfg_sel_e s, input logic [7:0] d);
      cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
      cyc();
      cfg_we = 1'b0;
   endtask

   task automatic do_ack();
      ack = 1'b1; cyc(); ack = 1'b0;
   endtask

   task automatic do_eoi();
      eoi = 1'b1; cyc(); eoi = 1'b0;
   endtask

   task automatic expect_vec(input string tag, input logic [7:0] v);
      @(negedge clk);
      chk(tag, 32'(vec_valid), 32'd1);
      chk(tag, 32'(vec_out), 32'(v));
      chk(tag, 32'(casc_sel), 32'd0);
   endtask

   task automatic expect_int(input string tag, input logic v);
      @(negedge clk);
      chk(tag, 32'(int_out), 32'(v));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog (all requirements) actual=running expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : stim
      cyc(3);
      rst_n = 1'b1;
      cyc();
      run_cmp = 1'b1;
      @(negedge clk);
      chk("R12 reset int_out", 32'(int_out), 32'd0);
      chk("R12 reset cascade_out", 32'(cascade_out), 32'd0);
      chk("R12 reset vec_valid", 32'(vec_valid), 32'd0);
      chk("R12 reset casc_sel", 32'(casc_sel), 32'd0);
      irq[0] = 1'b1;
      cyc();
      expect_int("R12 line masked after reset", 1'b0);
      irq[0] = 1'b0;

      wr(CFG_BASE, 8'h15);   // vectors 0xA8..0xAF
      wr(CFG_TRIG, 8'h00);
      wr(CFG_MASK, 8'h00);

      // R1 edge mode, held high after service
      irq[3] = 1'b1; cyc();
      expect_int("R1 rise sets request", 1'b1);
      do_ack();
      expect_vec("R8 vector line 3", 8'hAB);
      do_eoi();
      cyc(3);
      expect_int("R1 held high no re-request", 1'b0);
      irq[3] = 1'b0; cyc();
      irq[3] = 1'b1; cyc();
      expect_int("R1 new rise re-requests", 1'b1);
      do_ack(); do_eoi();
      irq[3] = 1'b0; cyc();

      // R3 / R9 vanished edge request
      irq[5] = 1'b1; cyc();
      irq[5] = 1'b0; cyc();
      expect_int("R3 fall clears request", 1'b0);
      do_ack();
      expect_vec("R9 spurious vector", 8'hAF);
      irq[6] = 1'b1; cyc();
      expect_int("R9 no in-service left by spurious", 1'b1);
      do_ack();
      expect_vec("R8 vector line 6", 8'hAE);
      do_eoi();
      irq[6] = 1'b0; cyc();

      // R4 masked after latching
      irq[4] = 1'b1; cyc();
      wr(CFG_MASK, 8'h10);
      expect_int("R4 masked latched request", 1'b0);
      do_ack();
      expect_vec("R4 masked line not served", 8'hAF);
      irq[4] = 1'b0; cyc();
      wr(CFG_MASK, 8'h00);
      cyc();
      expect_int("R4 nothing left after unmask", 1'b0);

      // R2 level mode
      wr(CFG_TRIG, 8'h10);
      irq[4] = 1'b1; cyc();
      do_ack();
      expect_vec("R2 level line 4", 8'hAC);
      do_eoi();
      expect_int("R2 level re-request", 1'b1);
      irq[4] = 1'b0; cyc();
      expect_int("R3 level fall clears", 1'b0);
      wr(CFG_TRIG, 8'h00);

      // R5 simultaneous
      irq[2] = 1'b1; irq[6] = 1'b1; cyc();
      do_ack();
      expect_vec("R5 lowest index wins", 8'hAA);
      do_eoi();
      do_ack();
      expect_vec("R5 next line served", 8'hAE);
      do_eoi();
      irq[2] = 1'b0; irq[6] = 1'b0; cyc();

      // R6 / R7 nesting
      irq[5] = 1'b1; cyc();
      do_ack();
      expect_vec("R8 vector line 5", 8'hAD);
      irq[6] = 1'b1; cyc();
      expect_int("R6 lower line blocked", 1'b0);
      chk("R10 pending visible while blocked", 32'(cascade_out), 32'd1);
      irq[1] = 1'b1; cyc();
      expect_int("R6 higher line preempts", 1'b1);
      do_ack();
      expect_vec("R6 vector line 1", 8'hA9);
      do_eoi();
      irq[3] = 1'b1; cyc();
      expect_int("R7 eoi retired line 1 not 5", 1'b1);
      do_ack();
      expect_vec("R7 vector line 3", 8'hAB);
      do_eoi(); do_eoi();
      expect_int("R6 blocked line released", 1'b1);
      do_ack();
      expect_vec("R6 vector line 6", 8'hAE);
      do_eoi();
      irq = '0; cyc();

      // R11 cascade on line 2
      wr(CFG_CASC, 8'h0A);
      irq[2] = 1'b1; cyc();
      do_ack();
      @(negedge clk);
      chk("R11 casc_sel pulse", 32'(casc_sel), 32'd1);
      chk("R11 no vector", 32'(vec_valid), 32'd0);
      do_eoi();
      expect_int("R11 cascade line level sensitive", 1'b1);
      wr(CFG_MASK, 8'h04);
      @(negedge clk);
      chk("R10 masked cascade line", 32'(cascade_out), 32'd0);
      wr(CFG_MASK, 8'h00);
      irq[2] = 1'b0; cyc();
      irq[2] = 1'b1; cyc();
      irq[2] = 1'b0; cyc();
      do_ack();
      expect_vec("R9 vanished cascade gives own line 7", 8'hAF);
      cyc(3);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule